// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned operands of a configurable width and raises exactly one of three flags: greater, less or equal. It is purely combinational. Each bit position first forms a difference flag. The flags are grouped into four-bit slices. Each slice reports whether it is fully equal, and a logarithmic AND prefix carries that "everything above is equal" condition down from the most significant slice.

Inside a slice, a bit is enabled only when the slice itself is enabled and every higher bit in the slice matches. An enabled bit places a two-bit code on a pair of buses, named the high-side bus and the low-side bus. A disabled bit places zeros on both. At most one position can therefore drive a non-zero code. An OR reduction of each bus yields the final decision.

The block suits sorting networks, priority selection and limit checks, where a wide compare must settle in one cycle of surrounding logic.

Top module: `prefix_cmp`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i` over all WIDTH bits.
- R2: `gt_o` is 1 exactly when `a_i` is greater than `b_i` as unsigned numbers.
- R3: `lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned numbers.
- R4: For every input pair, exactly one of `gt_o`, `lt_o` and `eq_o` is 1.
- R5: The most significant differing bit alone decides the result. When operands differ first at bit k, the values of all bits below k have no effect on the outputs, including when the lower bits favour the other operand and when k lies on a four-bit slice boundary. Internally, at most one bit position drives a non-zero code: 10 for a 1 against a 0, and 01 for a 0 against a 1.
- R6: A difference that exists only in bit 0 is still resolved correctly, through the full enable chain.
- R7: WIDTH is a positive multiple of 4. The behaviour of R1 to R6 holds for every legal WIDTH, including 16 and 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | a_i greater than b_i |
| lt_o | output | 1 | a_i less than b_i |
| eq_o | output | 1 | a_i equal to b_i |

## Verification
Two mechanisms can act on the same evaluation: the slice-level prefix mask and the bit-level mask inside a slice. When the first difference sits just below a slice boundary, both are in force at once, with lower-order bits that would vote the opposite way if left unmasked. The bench provokes this with paired operands such as 0x10 against 0x0F, and with random operands that differ in a single random bit under a common random prefix. Each result is judged against the unsigned relational operators, on a 128-bit and a 16-bit instance.

// File: rtl/prefix_cmp_pkg.sv
// Package: shared constants and decision encoding for the prefix comparator.
// Assumes: slices are always four bits wide.
package prefix_cmp_pkg;
    localparam int unsigned SLICE_W = 4;

    // Two-bit decision code formed from the OR of the high-side and low-side buses.
    typedef enum logic [1:0] {
        DEC_EQ = 2'b00,
        DEC_LT = 2'b01,
        DEC_GT = 2'b10
    } dec_code_t;
endpackage

// File: rtl/prefix_cmp_slice.sv
// Module: one four-bit slice of the comparator.
// Forms the per-bit difference flags and the slice-equal flag. Emits a masked
// two-bit code per bit. A bit is enabled only when en_i is high and all more
// significant bits of this slice match.
// Assumes: bit 3 is the most significant bit of the slice.
module prefix_cmp_slice
    import prefix_cmp_pkg::*;
(
    input  logic [SLICE_W-1:0] a_i,
    input  logic [SLICE_W-1:0] b_i,
    input  logic               en_i,
    output logic               same_o,
    output logic [SLICE_W-1:0] hi_o,
    output logic [SLICE_W-1:0] lo_o
);
    logic [SLICE_W-1:0] diff;
    logic [SLICE_W-1:0] bit_en;

    // Difference flag per bit.
    assign diff   = a_i ^ b_i;
    // Slice is fully equal when no bit differs.
    assign same_o = ~(|diff);

    for (genvar j = 0; j < SLICE_W; j++) begin : g_bit
        if (j == SLICE_W - 1) begin : g_top
            // Top bit of the slice depends only on the slice enable.
            assign bit_en[j] = en_i;
        end else begin : g_lower
            // Lower bits also need every higher bit of the slice to match.
            assign bit_en[j] = en_i & ~(|diff[SLICE_W-1:j+1]);
        end
        // Masked code: 10 when a is 1 and b is 0, 01 when a is 0 and b is 1.
        assign hi_o[j] = bit_en[j] &  a_i[j] & ~b_i[j];
        assign lo_o[j] = bit_en[j] & ~a_i[j] &  b_i[j];
    end
endmodule

// File: rtl/prefix_cmp_chain.sv
// Module: AND prefix across slice-equal flags, most significant slice first.
// Index 0 is the most significant slice. en_o[k] is high when every slice
// above k is equal. all_o is high when every slice is equal.
// Assumes: NSLICE >= 1. Every gate has fan-in two and the depth is log2(NSLICE).
module prefix_cmp_chain #(
    parameter int unsigned NSLICE = 32
) (
    input  logic [NSLICE-1:0] same_i,
    output logic [NSLICE-1:0] en_o,
    output logic              all_o
);
    localparam int unsigned LEVELS = (NSLICE > 1) ? $clog2(NSLICE) : 0;

    logic [NSLICE-1:0] lvl [LEVELS+1];

    // Level 0 is the raw slice-equal vector.
    assign lvl[0] = same_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar k = 0; k < NSLICE; k++) begin : g_node
            if (k >= (1 << l)) begin : g_and
                // Merge with the span that lies 2^l slices higher.
                assign lvl[l+1][k] = lvl[l][k] & lvl[l][k-(1<<l)];
            end else begin : g_pass
                // Nothing above to merge; pass through.
                assign lvl[l+1][k] = lvl[l][k];
            end
        end
    end

    // Exclusive prefix: a slice is enabled by all slices strictly above it.
    assign en_o[0] = 1'b1;
    for (genvar k = 1; k < NSLICE; k++) begin : g_en
        assign en_o[k] = lvl[LEVELS][k-1];
    end
    // Inclusive prefix over every slice.
    assign all_o = lvl[LEVELS][NSLICE-1];
endmodule

// File: rtl/prefix_cmp_decide.sv
// Module: OR reduction of the two code buses into the three result flags.
// Assumes: at most one position drives a non-zero code.
module prefix_cmp_decide
    import prefix_cmp_pkg::*;
#(
    parameter int unsigned WIDTH = 128
) (
    input  logic [WIDTH-1:0] hi_bus_i,
    input  logic [WIDTH-1:0] lo_bus_i,
    input  logic             all_same_i,
    output logic             gt_o,
    output logic             lt_o,
    output logic             eq_o
);
    dec_code_t code;

    // Collapse each bus into one bit and form the decision code.
    assign code = dec_code_t'({|hi_bus_i, |lo_bus_i});

    // Decode the code. Equality is also qualified by the prefix chain.
    always_comb begin
        gt_o = (code == DEC_GT);
        lt_o = (code == DEC_LT);
        eq_o = (code == DEC_EQ) & all_same_i;
    end
endmodule

// File: rtl/prefix_cmp.sv
// Module: top of the prefix-tree magnitude comparator.
// Splits the operands into four-bit slices, most significant first. Chains
// their equality through the AND prefix and reduces the masked code buses.
// Assumes: WIDTH is a positive multiple of 4. Purely combinational.
module prefix_cmp
    import prefix_cmp_pkg::*;
#(
    parameter int unsigned WIDTH = 128
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             gt_o,
    output logic             lt_o,
    output logic             eq_o
);
    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    initial begin
        // Elaboration-time guard on the width parameter.
        if (WIDTH == 0 || (WIDTH % SLICE_W) != 0)
            $error("prefix_cmp: WIDTH must be a positive multiple of 4");
    end

    logic [NSLICE-1:0] same;
    logic [NSLICE-1:0] en;
    logic              all_same;
    logic [WIDTH-1:0]  left_bus;
    logic [WIDTH-1:0]  right_bus;

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        localparam int unsigned TOP = WIDTH - 1 - k * SLICE_W;
        // Slice k covers bits TOP down to TOP-3. Slice 0 is the most significant.
        prefix_cmp_slice u_slice (
            .a_i    (a_i[TOP -: SLICE_W]),
            .b_i    (b_i[TOP -: SLICE_W]),
            .en_i   (en[k]),
            .same_o (same[k]),
            .hi_o   (left_bus[TOP -: SLICE_W]),
            .lo_o   (right_bus[TOP -: SLICE_W])
        );
    end

    prefix_cmp_chain #(.NSLICE(NSLICE)) u_chain (
        .same_i (same),
        .en_o   (en),
        .all_o  (all_same)
    );

    prefix_cmp_decide #(.WIDTH(WIDTH)) u_decide (
        .hi_bus_i   (left_bus),
        .lo_bus_i   (right_bus),
        .all_same_i (all_same),
        .gt_o       (gt_o),
        .lt_o       (lt_o),
        .eq_o       (eq_o)
    );
endmodule

// File: rtl/prefix_cmp_chk.sv
// Module: assertion checker bound to prefix_cmp.
// The block has no clock, so the checks are immediate assertions on settled
// combinational values.
module prefix_cmp_chk #(
    parameter int unsigned WIDTH = 128
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             gt_o,
    input logic             lt_o,
    input logic             eq_o,
    input logic [WIDTH-1:0] left_bus,
    input logic [WIDTH-1:0] right_bus
);
    // Relate the outputs to the operands and the internal buses to each other.
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            assert_eq_match_R1: assert (eq_o == (a_i == b_i));
            assert_gt_match_R2: assert (gt_o == (a_i > b_i));
            assert_lt_match_R3: assert (lt_o == (a_i < b_i));
            assert_one_flag_R4: assert ($countones({gt_o, lt_o, eq_o}) == 1);
            assert_single_code_R5: assert ($countones(left_bus | right_bus) <= 1);
            assert_no_both_R5: assert ((left_bus & right_bus) == '0);
        end
    end
endmodule

bind prefix_cmp prefix_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i       (a_i),
    .b_i       (b_i),
    .gt_o      (gt_o),
    .lt_o      (lt_o),
    .eq_o      (eq_o),
    .left_bus  (left_bus),
    .right_bus (right_bus)
);

// File: tb/prefix_cmp_tb.sv
// Bench: directed vector table plus random and single-bit-difference sweeps
// on a 128-bit and a 16-bit instance. Expected flags come from the unsigned
// relational operators.
module prefix_cmp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 128;
    localparam int W2 = 16;
    localparam int NVEC = 9;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]  a, b;
    logic          gt, lt, eq;
    logic [W2-1:0] a16, b16;
    logic          gt16, lt16, eq16;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    prefix_cmp #(.WIDTH(W)) u_dut (
        .a_i(a), .b_i(b), .gt_o(gt), .lt_o(lt), .eq_o(eq));

    prefix_cmp #(.WIDTH(W2)) u_dut16 (
        .a_i(a16), .b_i(b16), .gt_o(gt16), .lt_o(lt16), .eq_o(eq16));

    // Vector layout: {a, b, expected {gt, lt}}; 00 means equal.
    localparam logic [2*W+1:0] VEC [NVEC] = '{
        {128'h0, 128'h0, 2'b00},                                         // R1
        {{128{1'b1}}, {128{1'b1}}, 2'b00},                               // R1
        {128'h8000_0000_0000_0000_0000_0000_0000_0000,
         128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'b10},           // R5
        {128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
         128'h8000_0000_0000_0000_0000_0000_0000_0000, 2'b01},           // R5
        {128'h1, 128'h0, 2'b10},                                         // R6
        {{{127{1'b1}}, 1'b0}, {128{1'b1}}, 2'b01},                       // R6
        {128'h10, 128'h0F, 2'b10},                                       // R5 slice edge
        {128'hDEAD_BEEF_0000_0000_0000_0000_0000_0000,
         128'hDEAD_BEEF_0000_0000_0000_0000_0000_0001, 2'b01},           // R6
        {128'h0F00, 128'h1000, 2'b01}                                    // R5 slice edge
    };

    function automatic logic [W-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Compare the three 128-bit outputs against the expected code.
    task automatic chk128(input logic [1:0] exp, input string tag);
        logic [2:0] e;
        logic [2:0] got;
        e   = {exp == 2'b10, exp == 2'b01, exp == 2'b00};
        got = {gt, lt, eq};
        n_chk++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h got gt/lt/eq=%b expected=%b", tag, a, b, got, e);
        end
    endtask

    // Compare the 16-bit instance against the relational operators.
    task automatic chk16(input string tag);
        logic [2:0] e;
        logic [2:0] got;
        e   = {a16 > b16, a16 < b16, a16 == b16};
        got = {gt16, lt16, eq16};
        n_chk++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: a=%h b=%h got gt/lt/eq=%b expected=%b", tag, a16, b16, got, e);
        end
    endtask

    function automatic logic [1:0] ref_code(input logic [W-1:0] x, input logic [W-1:0] y);
        return {x > y, x < y};
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; a16 = '0; b16 = '0;
        @(negedge clk);
        #(CLK_PERIOD/4);
        // Initial state, zero operands: equal with one flag (R1, R4).
        chk128(2'b00, "R1_R4 initial");
        chk16("R1_R4 initial w16");

        // Directed table (R1, R5, R6).
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            a = VEC[i][2*W+1 -: W];
            b = VEC[i][W+1 -: W];
            #(CLK_PERIOD/4);
            chk128(VEC[i][1:0], $sformatf("R1_R5_R6 table %0d", i));
        end

        // Random operands (R2, R3, R4).
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            a = rnd128();
            b = (i % 5 == 0) ? a : rnd128();
            #(CLK_PERIOD/4);
            chk128(ref_code(a, b), "R2_R3_R4 random");
        end

        // Single-bit difference at every position, with a common random prefix
        // and opposing lower bits (R5, R7).
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            a = rnd128();
            a[k] = 1'b1;
            b = a;
            b[k] = 1'b0;
            for (int j = 0; j < k; j++) begin
                a[j] = 1'b0;
                b[j] = 1'b1;
            end
            if (k % 2 == 1) begin
                logic [W-1:0] t;
                t = a; a = b; b = t;
            end
            #(CLK_PERIOD/4);
            chk128(ref_code(a, b), $sformatf("R5 diff at bit %0d", k));
        end

        // 16-bit instance: single-bit sweeps and random operands (R7).
        for (int k = 0; k < W2; k++) begin
            @(negedge clk);
            a16 = W2'($urandom);
            b16 = a16 ^ (W2'(1) << k);
            #(CLK_PERIOD/4);
            chk16("R7 w16 single bit");
        end
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            a16 = W2'($urandom);
            b16 = (i % 4 == 0) ? a16 : W2'($urandom);
            #(CLK_PERIOD/4);
            chk16("R7 w16 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule